// File: doc/BRIEF.md
# Z80 Peripheral Bus Glue

This block sits between a Z80-style CPU bus and two peripherals on one card: a parallel I/O controller that can raise vectored interrupts, and a small register block that fronts a bus interface. It turns I/O cycles in an eight-address window into one chip enable for the parallel controller, plus separate read and write strobes for the register block. It drives the enable and direction of the card's data buffer. It also produces a delayed copy of the I/O request for the controller.

Two pieces of timing matter most. The controller has no reset pin of its own, so the block resets it when M1 is held low by itself, with no read and no I/O request, for a run of clocks. The block also pulls the wait line for a fixed number of clocks at the start of each interrupt-acknowledge cycle, so that the mode-2 vector is valid when the CPU samples it. All logic is synchronous to the CPU clock. Every output is registered, so each one answers the bus state sampled at the previous rising edge.

Top module: `zbus_glue`

## Requirements
- R1: While the card reset is in force, every output holds its idle value. In that state pio_ce_n, reg_rd_n, reg_wr_n, buf_en_n, wait_n and iorq_dly_n are 1, buf_to_cpu is 0, and pio_rst_n is 0. The card reset is in force from the first edge that samples rst_n low. An active wait is dropped at once.
- R2: After an edge that samples an I/O cycle (iorq_n=0, m1_n=1) with read or write at addresses C0h–C3h, pio_ce_n is 0 for the next cycle.
- R3: An I/O read at C4h–C7h drives reg_rd_n to 0 for the next cycle, and an I/O write there drives reg_wr_n to 0. The register strobes and pio_ce_n are never low together.
- R4: Addresses outside C0h–C7h, and cycles with iorq_n=1, assert no strobe and leave the buffer disabled.
- R5: buf_en_n is 0 after any card I/O access or any interrupt-acknowledge cycle (m1_n=0, iorq_n=0). buf_to_cpu is 1 only for a card read or an acknowledge.
- R6: pio_rst_n goes to 0 after the second consecutive edge that samples m1_n=0, rd_n=1 and iorq_n=1 (parameter RST_MIN_CYCLES, default 2). It returns to 1 after the first edge where that condition is gone.
- R7: M1 together with rd_n=0 (an opcode fetch) or with iorq_n=0 never resets the controller, however long it lasts. A single lone M1 clock does not reset it either.
- R8: At the first edge that samples an acknowledge, wait_n goes to 0. It stays there for exactly WAIT_CYCLES clocks (default 2) and is then released.
- R9: wait_n never goes low in a plain I/O or memory cycle. An acknowledge held over many clocks produces only one wait pulse.
- R10: iorq_dly_n repeats iorq_n one clock later.
- R11: rst_n passes through a two-stage synchronizer. After rst_n rises, the outputs first follow the bus at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | External card reset, active low |
| addr | input | 8 | Low byte of the CPU address bus |
| m1_n | input | 1 | CPU M1 status, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| pio_ce_n | output | 1 | Parallel I/O controller chip enable |
| reg_rd_n | output | 1 | Register block read strobe |
| reg_wr_n | output | 1 | Register block write strobe |
| buf_en_n | output | 1 | Data buffer enable |
| buf_to_cpu | output | 1 | Buffer direction, 1 = toward CPU |
| pio_rst_n | output | 1 | Reset to the parallel I/O controller |
| wait_n | output | 1 | CPU wait request |
| iorq_dly_n | output | 1 | Delayed I/O request for the controller |

## Verification
The hardest states to reach from the ports involve the counters meeting bus changes. A lone M1 can end exactly one clock short of the reset threshold. An acknowledge can stay asserted well past its wait pulse. An external reset can arrive in the middle of a wait. The stimulus walks M1 runs of one, two and four clocks, opcode fetches of several clocks, short and long acknowledges, and a reset issued one clock into a wait. A behavioural model in the bench predicts every output on every clock.

// File: rtl/zbg_pkg.sv
`timescale 1ns/1ps
// Shared types for the peripheral bus glue.
// Assumes CPU strobes arrive active low and are converted once at the top.
package zbg_pkg;
    // CPU bus status, active-high internal form
    typedef struct packed {
        logic m1;
        logic iorq;
        logic rd;
        logic wr;
    } cpu_bus_t;

    // Interrupt-acknowledge condition: M1 and IORQ together
    function automatic logic is_ack(cpu_bus_t b);
        return b.m1 && b.iorq;
    endfunction

    // Ordinary I/O access: IORQ without M1
    function automatic logic is_io(cpu_bus_t b);
        return b.iorq && !b.m1;
    endfunction
endpackage

// File: rtl/zbg_rst_sync.sv
`timescale 1ns/1ps
// Reset conditioner: filters the external reset through a flop chain.
// The block may run only when the raw input and the chain's end both say so.
// Assumes rst_n may be asynchronous to clk.
module zbg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run_ok
);
    logic [STAGES-1:0] chain;

    // Shift the raw reset level through the synchronizer chain
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) chain <= rst_n;
        end else begin : g_many
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], rst_n};
        end
    endgenerate

    assign run_ok = rst_n && chain[STAGES-1];
endmodule

// File: rtl/zbg_decode.sv
`timescale 1ns/1ps
// Address decoder and buffer control.
// Splits an aligned window of 2**WIN_LOG2 I/O addresses at CARD_BASE:
// the lower half enables the parallel controller, and the upper half
// gives the register block its read and write strobes. Also drives the
// data buffer and the delayed IORQ. All outputs are registered.
module zbg_decode
    import zbg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CARD_BASE = 8'hC0,
    parameter int                WIN_LOG2  = 3,
    parameter int                DLY       = 1
) (
    input  logic              clk,
    input  logic              run_ok,
    input  logic [ADDR_W-1:0] addr,
    input  cpu_bus_t          bus,
    output logic              pio_ce_n,
    output logic              reg_rd_n,
    output logic              reg_wr_n,
    output logic              buf_en_n,
    output logic              buf_to_cpu,
    output logic              iorq_dly_n
);
    localparam int HALF_BIT = WIN_LOG2 - 1;

    logic card_hit, hit_pio, hit_reg, io_rd, io_wr, ack;

    // Combinational window match and cycle classification
    always_comb begin
        card_hit = (addr[ADDR_W-1:WIN_LOG2] == CARD_BASE[ADDR_W-1:WIN_LOG2]);
        hit_pio  = card_hit && !addr[HALF_BIT];
        hit_reg  = card_hit &&  addr[HALF_BIT];
        io_rd    = is_io(bus) && bus.rd;
        io_wr    = is_io(bus) && bus.wr;
        ack      = is_ack(bus);
    end

    // Register the strobes and the buffer controls
    always_ff @(posedge clk) begin
        if (!run_ok) begin
            pio_ce_n   <= 1'b1;
            reg_rd_n   <= 1'b1;
            reg_wr_n   <= 1'b1;
            buf_en_n   <= 1'b1;
            buf_to_cpu <= 1'b0;
        end else begin
            pio_ce_n   <= !(hit_pio && (io_rd || io_wr));
            reg_rd_n   <= !(hit_reg && io_rd);
            reg_wr_n   <= !(hit_reg && io_wr);
            buf_en_n   <= !((card_hit && (io_rd || io_wr)) || ack);
            buf_to_cpu <= (card_hit && io_rd) || ack;
        end
    end

    // Delay IORQ toward the controller by DLY clocks
    logic [DLY-1:0] iorq_sh;
    generate
        if (DLY == 1) begin : g_d1
            always_ff @(posedge clk) begin
                if (!run_ok) iorq_sh <= 1'b1;
                else         iorq_sh <= !bus.iorq;
            end
        end else begin : g_dn
            always_ff @(posedge clk) begin
                if (!run_ok) iorq_sh <= '1;
                else         iorq_sh <= {iorq_sh[DLY-2:0], !bus.iorq};
            end
        end
    endgenerate
    assign iorq_dly_n = iorq_sh[DLY-1];

    // A register read must open the buffer toward the CPU (R5)
    p_read_opens_buf_r5: assert property (@(posedge clk) disable iff (!run_ok)
        !reg_rd_n |-> (buf_to_cpu && !buf_en_n));
endmodule

// File: rtl/zbg_pio_reset.sv
`timescale 1ns/1ps
// Peripheral reset generator.
// Counts consecutive clocks in which M1 is low with no read and no I/O
// request, and resets the controller once the run reaches MIN_CYCLES.
// The external card reset also holds the controller in reset.
module zbg_pio_reset
    import zbg_pkg::*;
#(
    parameter int MIN_CYCLES = 2
) (
    input  logic     clk,
    input  logic     run_ok,
    input  cpu_bus_t bus,
    output logic     pio_rst_n
);
    localparam int CW = $clog2(MIN_CYCLES + 1);

    logic          lone;
    logic [CW-1:0] run_cnt, run_nxt;

    // Detect a lone M1 and compute the saturating run length
    always_comb begin
        lone = bus.m1 && !bus.rd && !bus.iorq;
        if (!lone)
            run_nxt = '0;
        else if (run_cnt == CW'(MIN_CYCLES))
            run_nxt = run_cnt;
        else
            run_nxt = run_cnt + 1'b1;
    end

    // Hold the run counter and the registered reset output
    always_ff @(posedge clk) begin
        if (!run_ok) begin
            run_cnt   <= '0;
            pio_rst_n <= 1'b0;
        end else begin
            run_cnt   <= run_nxt;
            pio_rst_n <= (run_nxt != CW'(MIN_CYCLES));
        end
    end

    // A fall of the controller reset needs a lone M1 just before it (R6)
    p_rst_needs_lone_r6: assert property (@(posedge clk) disable iff (!run_ok)
        $fell(pio_rst_n) |-> $past(lone));

    generate
        if (MIN_CYCLES >= 2) begin : g_two
            // One lone clock alone never resets (R7)
            p_no_single_m1_r7: assert property (@(posedge clk) disable iff (!run_ok)
                $fell(pio_rst_n) |-> $past(lone, 2));
        end
    endgenerate
endmodule

// File: rtl/zbg_ack_wait.sv
`timescale 1ns/1ps
// Wait generator for the interrupt-acknowledge cycle.
// The first clock that sees M1 with IORQ starts a wait of WAIT_CYCLES
// clocks. An acknowledge that stays asserted does not restart it.
module zbg_ack_wait
    import zbg_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic     clk,
    input  logic     run_ok,
    input  cpu_bus_t bus,
    output logic     wait_n
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic          ack, ack_q, start;
    logic [CW-1:0] left;

    // Find the leading clock of an acknowledge
    always_comb begin
        ack   = is_ack(bus);
        start = ack && !ack_q;
    end

    // Load and count down the wait window
    always_ff @(posedge clk) begin
        if (!run_ok) begin
            ack_q <= 1'b0;
            left  <= '0;
        end else begin
            ack_q <= ack;
            if (start)
                left <= CW'(WAIT_CYCLES);
            else if (left != '0)
                left <= left - 1'b1;
        end
    end

    assign wait_n = (left == '0);

    // A wait begins only after an acknowledge was sampled (R9)
    p_wait_only_ack_r9: assert property (@(posedge clk) disable iff (!run_ok)
        $fell(wait_n) |-> $past(ack));

    generate
        if (WAIT_CYCLES >= 2) begin : g_hold
            // The wait lasts longer than a single clock (R8)
            p_wait_holds_r8: assert property (@(posedge clk) disable iff (!run_ok)
                $fell(wait_n) |=> !wait_n);
        end
    endgenerate
endmodule

// File: rtl/zbus_glue.sv
`timescale 1ns/1ps
// Top of the peripheral bus glue: the reset conditioner, the decoder
// with buffer control, the controller reset generator and the
// acknowledge wait generator. CPU strobes are active low at the ports.
module zbus_glue
    import zbg_pkg::*;
#(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] CARD_BASE      = 8'hC0,
    parameter int                WIN_LOG2       = 3,
    parameter int                RST_MIN_CYCLES = 2,
    parameter int                WAIT_CYCLES    = 2,
    parameter int                IORQ_DLY       = 1,
    parameter int                SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              m1_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              pio_ce_n,
    output logic              reg_rd_n,
    output logic              reg_wr_n,
    output logic              buf_en_n,
    output logic              buf_to_cpu,
    output logic              pio_rst_n,
    output logic              wait_n,
    output logic              iorq_dly_n
);
    logic     run_ok;
    cpu_bus_t bus;

    // Convert the active-low CPU strobes to the internal form
    always_comb begin
        bus.m1   = !m1_n;
        bus.iorq = !iorq_n;
        bus.rd   = !rd_n;
        bus.wr   = !wr_n;
    end

    zbg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok)
    );

    zbg_decode #(
        .ADDR_W(ADDR_W), .CARD_BASE(CARD_BASE),
        .WIN_LOG2(WIN_LOG2), .DLY(IORQ_DLY)
    ) u_dec (
        .clk(clk), .run_ok(run_ok), .addr(addr), .bus(bus),
        .pio_ce_n(pio_ce_n), .reg_rd_n(reg_rd_n), .reg_wr_n(reg_wr_n),
        .buf_en_n(buf_en_n), .buf_to_cpu(buf_to_cpu), .iorq_dly_n(iorq_dly_n)
    );

    zbg_pio_reset #(.MIN_CYCLES(RST_MIN_CYCLES)) u_prst (
        .clk(clk), .run_ok(run_ok), .bus(bus), .pio_rst_n(pio_rst_n)
    );

    zbg_ack_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk(clk), .run_ok(run_ok), .bus(bus), .wait_n(wait_n)
    );

    // Controller enable and register strobes never overlap (R3)
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!run_ok)
        !(!pio_ce_n && (!reg_rd_n || !reg_wr_n)));

    // Waiting implies the buffer is turned toward the CPU or was (R5)
    p_ack_buf_r5: assert property (@(posedge clk) disable iff (!run_ok)
        $fell(wait_n) |-> (buf_to_cpu && !buf_en_n));
endmodule

// File: tb/sim_zbus_glue.sv
`timescale 1ns/1ps
// Bench: a behavioural model predicts every output each clock and is
// compared on the falling edge. Inputs are driven right after compare.
module sim_zbus_glue;
    localparam int W_CYC = 2;
    localparam int R_MIN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic pio_ce_n, reg_rd_n, reg_wr_n, buf_en_n, buf_to_cpu;
    logic pio_rst_n, wait_n, iorq_dly_n;

    always #2.5 clk = ~clk;

    zbus_glue u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .m1_n(m1_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .pio_ce_n(pio_ce_n), .reg_rd_n(reg_rd_n),
        .reg_wr_n(reg_wr_n), .buf_en_n(buf_en_n), .buf_to_cpu(buf_to_cpu),
        .pio_rst_n(pio_rst_n), .wait_n(wait_n), .iorq_dly_n(iorq_dly_n)
    );

    // ---------------- reference model ----------------
    int   n_cmp = 0, n_bad = 0;
    bit   armed = 0, done = 0;
    bit   sy1 = 0, sy2 = 0;
    int   lone_run = 0, wait_left = 0;
    bit   ack_prev = 0;
    logic e_ce = 1, e_rd = 1, e_wr = 1, e_en = 1, e_dir = 0;
    logic e_prst = 0, e_wait = 1, e_dly = 1;
    string phase = "R1";

    always @(posedge clk) begin
        bit ok, io, ack, card, up, lone;
        ok = rst_n && sy2;
        sy2 = sy1;
        sy1 = rst_n;
        io   = !iorq_n && m1_n;
        ack  = !iorq_n && !m1_n;
        card = (addr >= 8'hC0) && (addr <= 8'hC7);
        up   = addr >= 8'hC4;
        lone = !m1_n && rd_n && iorq_n;
        if (!ok) begin
            {e_ce, e_rd, e_wr, e_en, e_dir} = 5'b11110;
            e_prst = 0; e_wait = 1; e_dly = 1;
            lone_run = 0; wait_left = 0; ack_prev = 0;
        end else begin
            e_ce  = !(io && card && !up && (!rd_n || !wr_n));
            e_rd  = !(io && card && up && !rd_n);
            e_wr  = !(io && card && up && !wr_n);
            e_en  = !((io && card && (!rd_n || !wr_n)) || ack);
            e_dir = (io && card && !rd_n) || ack;
            e_dly = iorq_n;
            lone_run = lone ? ((lone_run < R_MIN) ? lone_run + 1 : R_MIN) : 0;
            e_prst = !(lone_run >= R_MIN);
            if (ack && !ack_prev) wait_left = W_CYC;
            else if (wait_left > 0) wait_left--;
            ack_prev = ack;
            e_wait = (wait_left == 0);
        end
    end

    task automatic chk(string nm, logic act, logic exp, string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s actual=%b expected=%b t=%0t",
                     req, phase, nm, act, exp, $time);
        end
    endtask

    // Compare every output at the falling edge
    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (armed) begin
                chk("pio_ce_n",   pio_ce_n,   e_ce,   "R2");
                chk("reg_rd_n",   reg_rd_n,   e_rd,   "R3");
                chk("reg_wr_n",   reg_wr_n,   e_wr,   "R3");
                chk("buf_en_n",   buf_en_n,   e_en,   "R5");
                chk("buf_to_cpu", buf_to_cpu, e_dir,  "R5");
                chk("pio_rst_n",  pio_rst_n,  e_prst, "R6");
                chk("wait_n",     wait_n,     e_wait, "R8");
                chk("iorq_dly_n", iorq_dly_n, e_dly,  "R10");
            end
        end
    endtask

    task automatic bus(logic [7:0] a, logic m1, logic io, logic rd, logic wr, int n);
        addr = a; m1_n = m1; iorq_n = io; rd_n = rd; wr_n = wr;
        tick(n);
    endtask

    task automatic idle(int n);
        bus(8'h00, 1, 1, 1, 1, n);
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        tick(3);
        armed = 1;
        tick(3);
        chk("pio_rst_n in reset", pio_rst_n, 1'b0, "R1");
        chk("wait_n in reset", wait_n, 1'b1, "R1");
        // R11: synchronizer release
        phase = "R11";
        rst_n = 1;
        tick(1);
        chk("pio_rst_n held", pio_rst_n, 1'b0, "R11");
        tick(1);
        chk("pio_rst_n still held", pio_rst_n, 1'b0, "R11");
        tick(1);
        chk("pio_rst_n released", pio_rst_n, 1'b1, "R11");
        idle(2);
        // R2 R3 R4: sweep across and around the window
        for (int a = 8'hBE; a <= 8'hC9; a++) begin
            phase = ((a >= 8'hC0) && (a <= 8'hC7)) ? ((a < 8'hC4) ? "R2" : "R3") : "R4";
            bus(8'(a), 1, 0, 0, 1, 2);
            idle(1);
            bus(8'(a), 1, 0, 1, 0, 2);
            idle(1);
        end
        // R4: memory cycles inside the window
        phase = "R4";
        bus(8'hC4, 1, 1, 0, 1, 2);
        bus(8'hC1, 1, 1, 1, 0, 2);
        bus(8'hC5, 0, 1, 0, 1, 2);
        idle(1);
        // R6 R7: lone M1 runs and opcode fetches
        phase = "R7";
        bus(8'h00, 0, 1, 1, 1, 1);
        idle(2);
        bus(8'h00, 0, 1, 0, 1, 5);
        idle(1);
        phase = "R6";
        bus(8'h00, 0, 1, 1, 1, 2);
        chk("pio_rst_n after two lone", pio_rst_n, 1'b0, "R6");
        bus(8'h00, 0, 1, 1, 1, 2);
        idle(1);
        chk("pio_rst_n after release", pio_rst_n, 1'b1, "R6");
        bus(8'h00, 0, 1, 1, 1, 1);
        bus(8'h00, 0, 1, 0, 1, 2);
        idle(2);
        // R8 R9: acknowledge cycles
        phase = "R8";
        bus(8'h00, 0, 0, 1, 1, 1);
        chk("wait low first", wait_n, 1'b0, "R8");
        bus(8'h00, 0, 0, 1, 1, 1);
        chk("wait low second", wait_n, 1'b0, "R8");
        phase = "R9";
        bus(8'h00, 0, 0, 1, 1, 5);
        chk("single pulse", wait_n, 1'b1, "R9");
        idle(2);
        bus(8'h00, 0, 0, 1, 1, 1);
        idle(4);
        bus(8'hC0, 1, 0, 0, 1, 4);
        chk("no wait on io", wait_n, 1'b1, "R9");
        idle(1);
        // R10: iorq pulses of varied length
        phase = "R10";
        bus(8'h10, 1, 0, 1, 0, 1);
        idle(1);
        bus(8'h10, 1, 0, 0, 1, 3);
        idle(2);
        // R1: reset arriving mid-wait
        phase = "R1";
        bus(8'h00, 0, 0, 1, 1, 1);
        rst_n = 0;
        tick(1);
        chk("wait dropped by reset", wait_n, 1'b1, "R1");
        idle(3);
        rst_n = 1;
        idle(4);
        phase = "R2";
        bus(8'hC2, 1, 0, 1, 0, 2);
        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule